// File: doc/BRIEF.md
# Memory-module configuration EEPROM read engine

This block turns one 32-bit command word into a single-byte random read from a configuration EEPROM on a memory module, over a two-wire serial bus. Software checks the busy flag, writes a command naming the device type, the slave selector and the byte address, then polls the 16-bit status word until busy clears. A read has succeeded only when the read-done flag is set and the bus-error flag is clear. Any other completion is a failure.

The bus sequence is fixed. It sends a start, the control byte with the write direction and the byte address. It then sends a repeated start and the control byte with the read direction, receives one data byte, answers it with a not-acknowledge, and ends with a stop. Each bus bit takes four ticks of an internal divider. A command bit can halve the bit rate. A missing acknowledge, an expired cycle limit, or a write request all end as a bus error. A command written while a transfer runs is dropped.

On a board, the slave selector is formed as channel*4 + slot, and EEPROMs on memory modules answer to device type 0xA.

Top module: `spd_cmd_engine`

## Requirements
- R1: After reset the status word is 0x0000. Whenever busy (status bit 12) is 0, scl_o is 1 and sda_oe_o is 0.
- R2: Command fields: device type in bits 31:28, slow-clock select in bit 27, 3-bit slave selector in bits 26:24, byte address in bits 23:16, and direction in bit 0, where 0 means read. A read sends {type, selector, 0}, then the address, then a repeated start, then {type, selector, 1}. It receives one byte, answers with a not-acknowledge, then sends a stop. On success the status reads 0x8000 | byte: bit 15 read-done = 1, bit 13 bus-error = 0, bit 12 busy = 0, data in bits 7:0, and all other bits 0.
- R3: Busy reads 1 from the cycle after a read command is accepted for exactly 156*L cycles, where L = DIV when bit 27 is 0 and L = 2*DIV when bit 27 is 1. Bits 15 and 13 read 0 while busy is 1.
- R4: A cmd_wr_i pulse while busy is 1 is ignored. The running transfer's result and duration are unchanged.
- R5: A missing acknowledge ends the transfer with a stop and the status 0x2000 (bus-error set, read-done and data cleared). When the first control byte is not acknowledged, busy lasts 44*L cycles.
- R6: When busy has been 1 for TIMEOUT_CYC cycles, the transfer is aborted. The status becomes 0x2000 and both bus lines are released. The next command runs normally.
- R7: A command with bit 0 = 1, written while idle, starts no bus activity. Busy stays 0 and the status reads 0x2000 from the next cycle.
- R8: The selector value channel*4 + slot reaches the matching slave for all eight values. An unpopulated selector completes as in R5.
- R9: Command bits 15:8 have no effect on a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_wr_i | input | 1 | Command write strobe, one cycle |
| cmd_i | input | 32 | Command word |
| status_o | output | 16 | Status word |
| scl_o | output | 1 | Serial clock line |
| sda_oe_o | output | 1 | Pull the data line low when 1 |
| sda_i | input | 1 | Data line as seen on the bus |

## Verification
The assertions assume sda_i is already synchronous to clk_i and stays stable between the tick that raises the clock line and the sampling tick. They also assume the slave changes the data line only while the clock line is low, and that cmd_wr_i is a single-cycle strobe. The bench's EEPROM model moves its drive only on falling clock-line edges and releases the line at every start and stop. After an aborted transfer the bench explicitly clears the model, so that no half-finished slave state holds the data line low. Sweeps cover every selector value against a populated/unpopulated pattern, several byte addresses, both bit rates, a wrong device type, the cycle limit, and strobes injected mid-transfer.

// File: rtl/spd_pkg.sv
package spd_pkg;

  typedef enum logic [2:0] {SK_START, SK_TX, SK_ACK, SK_RX, SK_STOP} slot_kind_e;
  typedef enum logic [1:0] {SB_CTRL_W, SB_ADDR, SB_CTRL_R, SB_NONE} slot_src_e;

  typedef struct packed {
    slot_kind_e  kind;
    slot_src_e   src;
    logic [2:0]  bit_idx;
  } slot_info_t;

  localparam int unsigned SLOT_W    = 6;
  localparam int unsigned LAST_SLOT = 38;   // stop slot, also the abort target

  // Status word bit positions
  localparam int unsigned ST_DONE = 15;
  localparam int unsigned ST_BERR = 13;
  localparam int unsigned ST_BUSY = 12;

  // Slot map: 0 start, 1-8 ctrl(w), 9 ack, 10-17 addr, 18 ack, 19 restart,
  // 20-27 ctrl(r), 28 ack, 29-36 data in, 37 master nack, 38 stop
  function automatic slot_info_t decode_slot(input logic [SLOT_W-1:0] s);
    slot_info_t r;
    r.kind    = SK_TX;
    r.src     = SB_NONE;
    r.bit_idx = 3'd0;
    if (s == 6'd0 || s == 6'd19)                   r.kind = SK_START;
    else if (s == 6'd9 || s == 6'd18 || s == 6'd28) r.kind = SK_ACK;
    else if (s >= 6'd29 && s <= 6'd36)             r.kind = SK_RX;
    else if (s == 6'd37)                           r.kind = SK_TX;
    else if (s >= 6'd38)                           r.kind = SK_STOP;
    else if (s <= 6'd8) begin
      r.src = SB_CTRL_W; r.bit_idx = 3'(6'd8 - s);
    end else if (s <= 6'd17) begin
      r.src = SB_ADDR;   r.bit_idx = 3'(6'd17 - s);
    end else begin
      r.src = SB_CTRL_R; r.bit_idx = 3'(6'd27 - s);
    end
    return r;
  endfunction

endpackage

// File: rtl/spd_tick_gen.sv
module spd_tick_gen #(
  parameter int unsigned DIV = 250
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic restart_i,
  input  logic slow_i,
  output logic tick_o
);
  localparam int unsigned CW = $clog2(2 * DIV + 1);

  logic [CW-1:0] cnt_q, lim;

  assign lim    = slow_i ? CW'(2 * DIV - 1) : CW'(DIV - 1);
  assign tick_o = run_i && (cnt_q == lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (!run_i || restart_i) cnt_q <= '0;
    else if (tick_o)             cnt_q <= '0;
    else                         cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/spd_watchdog.sv
module spd_watchdog #(
  parameter int unsigned LIMIT = 100000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic restart_i,
  output logic expire_o
);
  localparam int unsigned CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt_q;

  assign expire_o = run_i && (cnt_q == CW'(LIMIT - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  cnt_q <= '0;
    else if (!run_i || restart_i) cnt_q <= '0;
    else if (!expire_o)           cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/spd_phase_lines.sv
module spd_phase_lines
  import spd_pkg::*;
(
  input  slot_kind_e  kind_i,
  input  logic [1:0]  phase_i,
  input  logic        txbit_i,
  output logic        scl_o,
  output logic        sda_o     // 1 = released
);
  always_comb begin
    scl_o = (phase_i == 2'd1) || (phase_i == 2'd2);
    sda_o = 1'b1;
    case (kind_i)
      SK_START: sda_o = (phase_i < 2'd2);    // fall while clock high
      SK_TX:    sda_o = txbit_i;
      SK_STOP: begin
        scl_o = (phase_i != 2'd0);
        sda_o = (phase_i >= 2'd2);           // rise while clock high
      end
      default:  sda_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/spd_cmd_engine.sv
module spd_cmd_engine
  import spd_pkg::*;
#(
  parameter int unsigned DIV         = 250,
  parameter int unsigned TIMEOUT_CYC = 100000
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        cmd_wr_i,
  input  logic [31:0] cmd_i,
  output logic [15:0] status_o,
  output logic        scl_o,
  output logic        sda_oe_o,
  input  logic        sda_i
);
  logic              busy_q, done_q, berr_q, nack_q, slow_q;
  logic [7:0]        data_q, shift_q, addr_q;
  logic [6:0]        ctrl_q;
  logic [SLOT_W-1:0] slot_q;
  logic [1:0]        phase_q;
  logic              scl_q, sda_oe_q;

  logic       accept, tick, expire, txbit, line_scl, line_sda;
  logic [7:0] ctrl_w, ctrl_r;
  slot_info_t info;

  logic unused_cmd_bits;
  assign unused_cmd_bits = ^cmd_i[15:1];

  assign accept = cmd_wr_i && !busy_q;
  assign info   = decode_slot(slot_q);
  assign ctrl_w = {ctrl_q, 1'b0};
  assign ctrl_r = {ctrl_q, 1'b1};

  always_comb begin
    case (info.src)
      SB_CTRL_W: txbit = ctrl_w[info.bit_idx];
      SB_ADDR:   txbit = addr_q[info.bit_idx];
      SB_CTRL_R: txbit = ctrl_r[info.bit_idx];
      default:   txbit = 1'b1;               // not-acknowledge after data
    endcase
  end

  spd_tick_gen #(.DIV(DIV)) u_tick (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(busy_q), .restart_i(accept),
    .slow_i(slow_q), .tick_o(tick)
  );

  spd_watchdog #(.LIMIT(TIMEOUT_CYC)) u_wdog (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(busy_q), .restart_i(accept),
    .expire_o(expire)
  );

  spd_phase_lines u_lines (
    .kind_i(info.kind), .phase_i(phase_q), .txbit_i(txbit),
    .scl_o(line_scl), .sda_o(line_sda)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0; done_q <= 1'b0; berr_q <= 1'b0; nack_q <= 1'b0;
      slow_q <= 1'b0; data_q <= '0; shift_q <= '0; addr_q <= '0;
      ctrl_q <= '0; slot_q <= '0; phase_q <= '0;
      scl_q  <= 1'b1; sda_oe_q <= 1'b0;
    end else if (accept) begin
      done_q <= 1'b0;
      data_q <= '0;
      if (cmd_i[0]) begin
        berr_q <= 1'b1;                      // write requests are refused
      end else begin
        berr_q  <= 1'b0;
        busy_q  <= 1'b1;
        ctrl_q  <= {cmd_i[31:28], cmd_i[26:24]};
        addr_q  <= cmd_i[23:16];
        slow_q  <= cmd_i[27];
        slot_q  <= '0;
        phase_q <= '0;
        nack_q  <= 1'b0;
      end
    end else if (busy_q && expire) begin
      busy_q   <= 1'b0;
      berr_q   <= 1'b1;
      scl_q    <= 1'b1;
      sda_oe_q <= 1'b0;
    end else if (busy_q && tick) begin
      scl_q    <= line_scl;
      sda_oe_q <= !line_sda;
      phase_q  <= phase_q + 2'd1;
      if (phase_q == 2'd2) begin
        if (info.kind == SK_ACK && sda_i) nack_q  <= 1'b1;
        if (info.kind == SK_RX)           shift_q <= {shift_q[6:0], sda_i};
      end
      if (phase_q == 2'd3) begin
        if (info.kind == SK_STOP) begin
          busy_q <= 1'b0;
          done_q <= !nack_q;
          berr_q <= nack_q;
          data_q <= nack_q ? 8'h00 : shift_q;
        end else if (info.kind == SK_ACK && nack_q) begin
          slot_q <= SLOT_W'(LAST_SLOT);
        end else begin
          slot_q <= slot_q + 6'd1;
        end
      end
    end
  end

  always_comb begin
    status_o          = '0;
    status_o[ST_DONE] = done_q;
    status_o[ST_BERR] = berr_q;
    status_o[ST_BUSY] = busy_q;
    status_o[7:0]     = data_q;
  end

  assign scl_o    = scl_q;
  assign sda_oe_o = sda_oe_q;
endmodule

// File: rtl/spd_cmd_engine_chk.sv
module spd_cmd_engine_chk #(
  parameter int unsigned TIMEOUT_CYC = 100000
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       cmd_wr_i,
  input logic       cmd_rw_i,
  input logic       busy_i,
  input logic       done_i,
  input logic       berr_i,
  input logic       scl_i,
  input logic       sda_oe_i,
  input logic [6:0] ctrl_i,
  input logic [7:0] addr_i
);
  localparam int unsigned RW = $clog2(TIMEOUT_CYC + 2);

  logic [RW-1:0] run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     run_q <= '0;
    else if (busy_i) run_q <= run_q + 1'b1;
    else             run_q <= '0;
  end

  assert_idle_lines_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i |-> scl_i && !sda_oe_i);

  assert_flags_excl_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_i && berr_i));

  assert_flags_clear_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |-> !done_i && !berr_i);

  assert_busy_start_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_i) |-> $past(cmd_wr_i && !cmd_rw_i));

  assert_ignore_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i && cmd_wr_i |=> $stable(ctrl_i) && $stable(addr_i));

  assert_bounded_busy_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |-> run_q < RW'(TIMEOUT_CYC));

  assert_wr_flag_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_wr_i && !busy_i && cmd_rw_i |=> !busy_i && berr_i && !done_i);
endmodule

bind spd_cmd_engine spd_cmd_engine_chk #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cmd_wr_i(cmd_wr_i), .cmd_rw_i(cmd_i[0]),
  .busy_i(busy_q), .done_i(done_q), .berr_i(berr_q), .scl_i(scl_q),
  .sda_oe_i(sda_oe_q), .ctrl_i(ctrl_q), .addr_i(addr_q)
);

// File: tb/sim_spd_cmd_engine.sv
`timescale 1ns/1ps
module sim_spd_cmd_engine;
  localparam int DIV = 4;
  localparam int TO  = 1000;
  localparam logic [7:0] PRESENT = 8'b1011_0110;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_wr = 1'b0;
  logic [31:0] cmd = '0;
  logic [15:0] status;
  logic        scl, sda_oe;
  logic        stub_low = 1'b0;
  logic        stub_clr = 1'b0;
  wire         sda_bus = !(sda_oe | stub_low);

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  spd_cmd_engine #(.DIV(DIV), .TIMEOUT_CYC(TO)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .cmd_wr_i(cmd_wr), .cmd_i(cmd),
    .status_o(status), .scl_o(scl), .sda_oe_o(sda_oe), .sda_i(sda_bus)
  );

  function automatic logic [7:0] mem_byte(input logic [2:0] sa, input logic [7:0] a);
    int v;
    v = int'(sa) * 37 + int'(a) * 5 + 3;
    return v[7:0];
  endfunction

  function automatic logic [31:0] mk_cmd(input logic [3:0] dti, input logic slow,
      input logic [2:0] sa, input logic [7:0] ba, input logic [7:0] wd, input logic rw);
    return {dti, slow, sa, ba, wd, 7'd0, rw};
  endfunction

  // Behavioural EEPROM model: 0 idle, 1 ctrl in, 2 addr in, 3 data out, 4 ignore, 5 wait restart
  int         st = 0, bitc = 0;
  logic [7:0] sh = '0, ptr = '0, dbyte = '0;
  logic [2:0] ssa = '0;
  logic       ackph = 1'b0, ps = 1'b1, psd = 1'b1;

  always @(posedge scl or negedge scl or posedge sda_bus or negedge sda_bus or posedge stub_clr) begin
    if (stub_clr) begin
      st = 0; bitc = 0; ackph = 1'b0; stub_low = 1'b0;
    end else if (scl && ps && (sda_bus != psd)) begin
      ackph = 1'b0; stub_low = 1'b0; bitc = 0;
      if (!sda_bus) begin st = 1; sh = '0; end
      else st = 0;
    end else if (scl && !ps) begin
      if ((st == 1 || st == 2) && !ackph) begin
        sh = {sh[6:0], sda_bus}; bitc++;
      end else if (st == 3 && ackph && sda_bus) begin
        st = 4;
      end
    end else if (!scl && ps) begin
      if (ackph) begin
        ackph = 1'b0; stub_low = 1'b0;
        if (st == 3) begin bitc = 0; stub_low = !dbyte[7]; end
      end else if (st == 1 && bitc == 8) begin
        if (sh[7:4] == 4'hA && PRESENT[sh[3:1]]) begin
          ssa = sh[3:1]; stub_low = 1'b1; ackph = 1'b1; bitc = 0;
          if (sh[0]) begin st = 3; dbyte = mem_byte(ssa, ptr); end
          else st = 2;
        end else st = 4;
      end else if (st == 2 && bitc == 8) begin
        ptr = sh; stub_low = 1'b1; ackph = 1'b1; st = 5;
      end else if (st == 3) begin
        bitc++;
        if (bitc < 8) stub_low = !dbyte[7-bitc];
        else begin stub_low = 1'b0; ackph = 1'b1; end
      end
    end
    ps  = scl;
    psd = !(sda_oe | stub_low);
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // intr: 0 none, else inject c2 at busy cycle 50
  task automatic run_cmd(input logic [31:0] c, input bit intr, input logic [31:0] c2,
                         output int n, output logic [15:0] sw);
    @(negedge clk); cmd = c; cmd_wr = 1'b1;
    @(negedge clk); cmd_wr = 1'b0; cmd = '0;
    n = 0;
    forever begin
      if (!status[12]) break;
      n++;
      if (intr && n == 50) begin cmd = c2; cmd_wr = 1'b1; end
      else if (intr && n == 51) begin cmd = '0; cmd_wr = 1'b0; end
      @(negedge clk);
    end
    sw = status;
  endtask

  task automatic idle_lines(input string req);
    check(req, "idle scl", int'(scl), 1);
    check(req, "idle sda_oe", int'(sda_oe), 0);
  endtask

  task automatic run_all();
    int n;
    logic [15:0] sw;
    logic [2:0] sa;
    logic [7:0] ba, wd;
    int scl_low;

    repeat (5) @(negedge clk);
    check("R1", "reset status", int'(status), 16'h0000);
    idle_lines("R1");
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // Selector sweep: channel*4 + slot, three addresses each, varying bits 15:8
    for (int ch = 0; ch < 2; ch++) begin
      for (int sl = 0; sl < 4; sl++) begin
        for (int ai = 0; ai < 3; ai++) begin
          sa = 3'(ch * 4 + sl);
          ba = 8'(ai * 85 + int'(sa) * 3);
          wd = 8'(int'(sa) * 17 + ai * 90);
          run_cmd(mk_cmd(4'hA, 1'b0, sa, ba, wd, 1'b0), 1'b0, '0, n, sw);
          if (PRESENT[sa]) begin
            check("R8", "read status", int'(sw), int'({8'h80, mem_byte(sa, ba)}));
            check("R3", "busy length", n, 156 * DIV);
          end else begin
            check("R5", "absent status", int'(sw), 16'h2000);
            check("R5", "absent busy length", n, 44 * DIV);
          end
          idle_lines("R1");
        end
      end
    end

    // Write-data field ignored: same read, two different bits 15:8
    run_cmd(mk_cmd(4'hA, 1'b0, 3'd5, 8'h3C, 8'h00, 1'b0), 1'b0, '0, n, sw);
    check("R9", "wd=00", int'(sw), int'({8'h80, mem_byte(3'd5, 8'h3C)}));
    run_cmd(mk_cmd(4'hA, 1'b0, 3'd5, 8'h3C, 8'hFF, 1'b0), 1'b0, '0, n, sw);
    check("R9", "wd=FF", int'(sw), int'({8'h80, mem_byte(3'd5, 8'h3C)}));

    // Wrong device type: control byte not acknowledged
    run_cmd(mk_cmd(4'h5, 1'b0, 3'd2, 8'h10, 8'h00, 1'b0), 1'b0, '0, n, sw);
    check("R5", "bad type status", int'(sw), 16'h2000);
    check("R5", "bad type busy length", n, 44 * DIV);

    // Slow bit clock, unpopulated selector
    run_cmd(mk_cmd(4'hA, 1'b1, 3'd0, 8'h10, 8'h00, 1'b0), 1'b0, '0, n, sw);
    check("R3", "slow absent busy length", n, 44 * 2 * DIV);
    check("R5", "slow absent status", int'(sw), 16'h2000);

    // Slow full read exceeds the cycle limit
    run_cmd(mk_cmd(4'hA, 1'b1, 3'd1, 8'h20, 8'h00, 1'b0), 1'b0, '0, n, sw);
    check("R6", "timeout busy length", n, TO);
    check("R6", "timeout status", int'(sw), 16'h2000);
    idle_lines("R6");
    @(negedge clk); stub_clr = 1'b1;
    @(negedge clk); stub_clr = 1'b0;
    repeat (4) @(negedge clk);
    run_cmd(mk_cmd(4'hA, 1'b0, 3'd2, 8'h33, 8'h00, 1'b0), 1'b0, '0, n, sw);
    check("R6", "read after timeout", int'(sw), int'({8'h80, mem_byte(3'd2, 8'h33)}));

    // Write flag: immediate error, no bus activity
    run_cmd(mk_cmd(4'hA, 1'b0, 3'd1, 8'h44, 8'h55, 1'b1), 1'b0, '0, n, sw);
    check("R7", "write busy length", n, 0);
    check("R7", "write status", int'(sw), 16'h2000);
    scl_low = 0;
    for (int i = 0; i < 20; i++) begin
      if (!scl || sda_oe) scl_low++;
      @(negedge clk);
    end
    check("R7", "bus quiet after write", scl_low, 0);
    run_cmd(mk_cmd(4'hA, 1'b0, 3'd7, 8'h01, 8'h00, 1'b0), 1'b0, '0, n, sw);
    check("R7", "read after write", int'(sw), int'({8'h80, mem_byte(3'd7, 8'h01)}));

    // Commands while busy are dropped
    run_cmd(mk_cmd(4'hA, 1'b0, 3'd4, 8'h10, 8'h00, 1'b0), 1'b1,
            mk_cmd(4'hA, 1'b1, 3'd7, 8'h99, 8'h00, 1'b0), n, sw);
    check("R4", "read intruded status", int'(sw), int'({8'h80, mem_byte(3'd4, 8'h10)}));
    check("R4", "read intruded length", n, 156 * DIV);
    run_cmd(mk_cmd(4'hA, 1'b0, 3'd1, 8'hC8, 8'h00, 1'b0), 1'b1,
            mk_cmd(4'hA, 1'b0, 3'd2, 8'h00, 8'h00, 1'b1), n, sw);
    check("R4", "write intruded status", int'(sw), int'({8'h80, mem_byte(3'd1, 8'hC8)}));
    check("R4", "write intruded length", n, 156 * DIV);
    check("R2", "final idle status busy", int'(status[12]), 0);
  endtask

  initial begin
    bit timed_out;
    timed_out = 1'b0;
    fork
      run_all();
      begin
        repeat (190000) @(posedge clk);
        timed_out = 1'b1;
      end
    join_any
    disable fork;
    if (timed_out) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule